// File: doc/BRIEF.md
# VPD Capability Access Controller

This block holds the Vital Product Data capability structure of a configuration space and moves data between a 32-bit VPD data register and an external serial EEPROM. Software writes a byte address and a direction flag into the capability register. The block then moves four consecutive EEPROM bytes into or out of the data register through a byte-wide request/acknowledge interface, which an external serial-bus engine serves. When all four bytes are done, the block inverts the flag so that a polling loop can end.

There are two configuration-access ports. The primary port has full access to both registers. The secondary port always reads zero, and its writes have no effect. One enable input switches all VPD access on the primary port on or off. The lowest part of the EEPROM space is write-protected. A write command that touches any byte outside the writable window issues no EEPROM traffic and completes at once.

Top module: `vpd_cap_ctrl`

## Requirements
- R1: After reset, the capability word (select 0) reads 0x0000_0003, the data word (select 1) reads 0, and `ee_req` is low.
- R2: Bits 7:0 always read 0x03 and bits 15:8 always read 0x00. Bits 30:24 read 0. Writes to these bits have no effect. Bits 23:16 read back the last accepted address.
- R3: A primary write of the capability word with bit 31 = 0 starts a read from address A = bits 23:16. Bit 31 stays 0 until EEPROM bytes A, A+1, A+2 and A+3 (modulo 256) are all in data bits 7:0, 15:8, 23:16 and 31:24. Bit 31 then becomes 1.
- R4: A primary write with bit 31 = 1, to an address whose four bytes all lie in [64, 192), issues four EEPROM writes of data bytes 7:0 through 31:24 to A through A+3, lowest byte first. Bit 31 then returns to 0.
- R5: A write command in which any of the four byte addresses lies below 64 or at 192 or above issues no EEPROM request. Bit 31 reads 1 for one cycle and then 0.
- R6: `sec_rdata` is always 0, and secondary writes change no register and start no transfer.
- R7: While `vpd_enable` is 0, `pri_rdata` is 0, and primary writes change nothing and start no transfer.
- R8: While a transfer is in progress, primary writes to either register are ignored.
- R9: `ee_req` stays high with stable `ee_addr`, `ee_we` and `ee_wdata` until `ee_ack`. After each acknowledge it drops for one cycle.
- R10: Reset during a transfer drops `ee_req` at once and restores the reset values of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Primary-side asynchronous reset, active low |
| vpd_enable | input | 1 | VPD access enable |
| pri_sel | input | 1 | Primary register select: 0 capability, 1 data |
| pri_wr | input | 1 | Primary write strobe |
| pri_wdata | input | 32 | Primary write data |
| pri_rdata | output | 32 | Primary read data for the selected register |
| sec_sel | input | 1 | Secondary register select |
| sec_wr | input | 1 | Secondary write strobe |
| sec_wdata | input | 32 | Secondary write data |
| sec_rdata | output | 32 | Secondary read data, always zero |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | Request direction: 1 write, 0 read |
| ee_addr | output | 8 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | One-cycle acknowledge from the serial engine |
| ee_rdata | input | 8 | Read byte, valid with `ee_ack` |

## Verification
The bench aims at the edges of the write window. It sends commands that straddle 64 and 192, and one whose address wraps past 255. A design that checked only the start address would corrupt the protected bytes, and the read-back would show it. Commands and data writes issued during a read test the busy lockout: a design without it would fetch from the wrong address or overwrite assembled bytes. Reset in the middle of a transfer and secondary or disabled accesses check that no stray request leaves the block and no field moves.

// File: rtl/vpd_cap_pkg.sv
package vpd_cap_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ISSUE = 2'd1,
      SEQ_GAP   = 2'd2,
      SEQ_SKIP  = 2'd3
   } seq_state_e;

endpackage

// File: rtl/vpd_range_chk.sv
// Decides whether every byte of a multi-byte write lies inside the writable window.
module vpd_range_chk #(
   parameter int ADDR_W    = 8,
   parameter int LANES     = 4,
   parameter int RO_BYTES  = 64,
   parameter int VPD_BYTES = 192
) (
   input  logic [ADDR_W-1:0] start_addr,
   output logic              writable
);
   localparam logic [ADDR_W:0] LO_L = RO_BYTES[ADDR_W:0];
   localparam logic [ADDR_W:0] HI_L = VPD_BYTES[ADDR_W:0];

   if (VPD_BYTES > (1 << ADDR_W)) begin : g_bad_end
      $error("VPD_BYTES exceeds the address space");
   end
   if (RO_BYTES >= VPD_BYTES) begin : g_bad_ro
      $error("RO_BYTES must be below VPD_BYTES");
   end

   logic [LANES-1:0] lane_ok;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [ADDR_W-1:0] a_i;
      assign a_i        = start_addr + ADDR_W'(i);
      assign lane_ok[i] = ({1'b0, a_i} >= LO_L) && ({1'b0, a_i} < HI_L);
   end

   assign writable = &lane_ok;
endmodule

// File: rtl/vpd_byte_seq.sv
// Byte sequencer: walks LANES consecutive EEPROM bytes with a req/ack handshake.
module vpd_byte_seq
   import vpd_cap_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         start_we,
   input  logic                         start_skip,
   input  logic [ADDR_W-1:0]            start_addr,
   input  logic [LANES-1:0][BYTE_W-1:0] wr_lanes,
   input  logic                         ee_ack,
   output logic                         ee_req,
   output logic                         ee_we,
   output logic [ADDR_W-1:0]            ee_addr,
   output logic [BYTE_W-1:0]            ee_wdata,
   output logic [LANES-1:0]             lane_cap,
   output logic                         busy,
   output logic                         done
);
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

   if (LANES < 2) begin : g_bad_lanes
      $error("LANES must be at least 2");
   end

   seq_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] base_q;
   logic              we_q;
   logic              acked;
   logic              last_byte;

   assign acked     = (state_q == SEQ_ISSUE) && ee_ack;
   assign last_byte = (idx_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         base_q  <= '0;
         we_q    <= 1'b0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  idx_q   <= '0;
                  base_q  <= start_addr;
                  we_q    <= start_we;
                  state_q <= start_skip ? SEQ_SKIP : SEQ_ISSUE;
               end
            end
            SEQ_ISSUE: begin
               if (ee_ack) begin
                  if (last_byte) begin
                     state_q <= SEQ_IDLE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= SEQ_GAP;
                  end
               end
            end
            SEQ_GAP:  state_q <= SEQ_ISSUE;
            SEQ_SKIP: state_q <= SEQ_IDLE;
            default:  state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign ee_req   = (state_q == SEQ_ISSUE);
   assign ee_we    = we_q;
   assign ee_addr  = base_q + ADDR_W'(idx_q);
   assign ee_wdata = wr_lanes[idx_q];
   assign busy     = (state_q != SEQ_IDLE);
   assign done     = (acked && last_byte) || (state_q == SEQ_SKIP);

   for (genvar i = 0; i < LANES; i++) begin : g_cap
      assign lane_cap[i] = acked && !we_q && (idx_q == IDX_W'(i));
   end
endmodule

// File: rtl/vpd_data_lanes.sv
// Data register built from byte lanes; each lane loads from config or from the EEPROM.
module vpd_data_lanes #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [LANES-1:0][BYTE_W-1:0] cfg_wdata,
   input  logic [LANES-1:0]             lane_cap,
   input  logic [BYTE_W-1:0]            cap_byte,
   output logic [LANES-1:0][BYTE_W-1:0] lanes
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lanes[i] <= '0;
         end else if (lane_cap[i]) begin
            lanes[i] <= cap_byte;
         end else if (cfg_we) begin
            lanes[i] <= cfg_wdata[i];
         end
      end
   end
endmodule

// File: rtl/vpd_cap_ctrl.sv
// VPD capability register with EEPROM transfer control.
module vpd_cap_ctrl #(
   parameter int                ADDR_W    = 8,
   parameter int                BYTE_W    = 8,
   parameter int                DATA_W    = 32,
   parameter int                RO_BYTES  = 64,
   parameter int                VPD_BYTES = 192,
   parameter logic [BYTE_W-1:0] CAP_ID    = 8'h03,
   parameter logic [BYTE_W-1:0] NEXT_PTR  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vpd_enable,
   input  logic              pri_sel,
   input  logic              pri_wr,
   input  logic [DATA_W-1:0] pri_wdata,
   output logic [DATA_W-1:0] pri_rdata,
   input  logic              sec_sel,
   input  logic              sec_wr,
   input  logic [DATA_W-1:0] sec_wdata,
   output logic [DATA_W-1:0] sec_rdata,
   output logic              ee_req,
   output logic              ee_we,
   output logic [ADDR_W-1:0] ee_addr,
   output logic [BYTE_W-1:0] ee_wdata,
   input  logic              ee_ack,
   input  logic [BYTE_W-1:0] ee_rdata
);
   localparam int LANES    = DATA_W / BYTE_W;
   localparam int NP_LSB   = BYTE_W;
   localparam int ADDR_LSB = 2 * BYTE_W;
   localparam int FLAG_BIT = DATA_W - 1;

   if (DATA_W != 4 * BYTE_W) begin : g_bad_width
      $error("DATA_W must hold exactly four bytes");
   end
   if (ADDR_W != BYTE_W) begin : g_bad_addr
      $error("address field must be one byte wide");
   end

   logic                         flag_q;
   logic [ADDR_W-1:0]            addr_q;
   logic [LANES-1:0][BYTE_W-1:0] lanes;
   logic [LANES-1:0]             lane_cap;
   logic                         busy;
   logic                         done;
   logic                         writable;
   logic                         accept;
   logic                         cap_wr;
   logic                         dat_wr;
   logic                         cmd_we;
   logic [ADDR_W-1:0]            cmd_addr;
   logic [DATA_W-1:0]            cap_word;

   // Primary accesses are taken only when enabled and no transfer is running.
   assign accept   = vpd_enable && pri_wr && !busy;
   assign cap_wr   = accept && !pri_sel;
   assign dat_wr   = accept && pri_sel;
   assign cmd_we   = pri_wdata[FLAG_BIT];
   assign cmd_addr = pri_wdata[ADDR_LSB +: ADDR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         addr_q <= '0;
      end else if (cap_wr) begin
         flag_q <= cmd_we;
         addr_q <= cmd_addr;
      end else if (done) begin
         flag_q <= ~flag_q;
      end
   end

   vpd_range_chk #(
      .ADDR_W    (ADDR_W),
      .LANES     (LANES),
      .RO_BYTES  (RO_BYTES),
      .VPD_BYTES (VPD_BYTES)
   ) u_range (
      .start_addr (cmd_addr),
      .writable   (writable)
   );

   vpd_byte_seq #(
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W),
      .LANES  (LANES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (cap_wr),
      .start_we   (cmd_we),
      .start_skip (cmd_we && !writable),
      .start_addr (cmd_addr),
      .wr_lanes   (lanes),
      .ee_ack     (ee_ack),
      .ee_req     (ee_req),
      .ee_we      (ee_we),
      .ee_addr    (ee_addr),
      .ee_wdata   (ee_wdata),
      .lane_cap   (lane_cap),
      .busy       (busy),
      .done       (done)
   );

   vpd_data_lanes #(
      .BYTE_W (BYTE_W),
      .LANES  (LANES)
   ) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (dat_wr),
      .cfg_wdata (pri_wdata),
      .lane_cap  (lane_cap),
      .cap_byte  (ee_rdata),
      .lanes     (lanes)
   );

   always_comb begin
      cap_word                          = '0;
      cap_word[BYTE_W-1:0]              = CAP_ID;
      cap_word[NP_LSB +: BYTE_W]        = NEXT_PTR;
      cap_word[ADDR_LSB +: ADDR_W]      = addr_q;
      cap_word[FLAG_BIT]                = flag_q;
   end

   assign pri_rdata = !vpd_enable ? '0 : (pri_sel ? DATA_W'(lanes) : cap_word);

   // The secondary port has no path into VPD state.
   logic unused_sec;
   assign unused_sec = ^{sec_sel, sec_wr, sec_wdata};
   assign sec_rdata  = '0;
endmodule

// File: rtl/vpd_cap_chk.sv
module vpd_cap_chk #(
   parameter int ADDR_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int DATA_W    = 32,
   parameter int RO_BYTES  = 64,
   parameter int VPD_BYTES = 192
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vpd_enable,
   input logic [DATA_W-1:0] pri_rdata,
   input logic [DATA_W-1:0] sec_rdata,
   input logic              ee_req,
   input logic              ee_we,
   input logic [ADDR_W-1:0] ee_addr,
   input logic [BYTE_W-1:0] ee_wdata,
   input logic              ee_ack
);
   localparam logic [ADDR_W:0] LO_L = RO_BYTES[ADDR_W:0];
   localparam logic [ADDR_W:0] HI_L = VPD_BYTES[ADDR_W:0];

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_req && !ee_ack |=> ee_req);

   // R9
   req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_req && !ee_ack |=> $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata));

   // R9
   req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_req && ee_ack |=> !ee_req);

   // R5
   ro_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_req && ee_we |-> ({1'b0, ee_addr} >= LO_L) && ({1'b0, ee_addr} < HI_L));

   // R6
   sec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_rdata == '0);

   // R7
   dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vpd_enable |-> pri_rdata == '0);
endmodule

bind vpd_cap_ctrl vpd_cap_chk #(
   .ADDR_W    (ADDR_W),
   .BYTE_W    (BYTE_W),
   .DATA_W    (DATA_W),
   .RO_BYTES  (RO_BYTES),
   .VPD_BYTES (VPD_BYTES)
) u_vpd_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vpd_enable (vpd_enable),
   .pri_rdata  (pri_rdata),
   .sec_rdata  (sec_rdata),
   .ee_req     (ee_req),
   .ee_we      (ee_we),
   .ee_addr    (ee_addr),
   .ee_wdata   (ee_wdata),
   .ee_ack     (ee_ack)
);

// File: tb/vpd_cap_ctrl_bench.sv
module vpd_cap_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;
   localparam int NVEC       = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vpd_enable = 1'b1;
   logic        pri_sel = 1'b0;
   logic        pri_wr = 1'b0;
   logic [31:0] pri_wdata = '0;
   logic [31:0] pri_rdata;
   logic        sec_sel = 1'b0;
   logic        sec_wr = 1'b0;
   logic [31:0] sec_wdata = '0;
   logic [31:0] sec_rdata;
   logic        ee_req;
   logic        ee_we;
   logic [7:0]  ee_addr;
   logic [7:0]  ee_wdata;
   logic        ee_ack;
   logic [7:0]  ee_rdata;

   int total = 0;
   int bad = 0;
   int wr_cnt = 0;
   int req_cnt = 0;
   bit finished = 1'b0;

   logic [7:0] eep [256];
   logic [7:0] ref_mem [256];
   int         lat_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   vpd_cap_ctrl u_vpd_cap_ctrl (
      .clk(clk), .rst_n(rst_n), .vpd_enable(vpd_enable),
      .pri_sel(pri_sel), .pri_wr(pri_wr), .pri_wdata(pri_wdata), .pri_rdata(pri_rdata),
      .sec_sel(sec_sel), .sec_wr(sec_wr), .sec_wdata(sec_wdata), .sec_rdata(sec_rdata),
      .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
      .ee_ack(ee_ack), .ee_rdata(ee_rdata)
   );

   // Behavioural serial-engine responder with fixed latency.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ee_ack   <= 1'b0;
         ee_rdata <= '0;
         lat_cnt  <= 0;
      end else begin
         ee_ack <= 1'b0;
         if (ee_req && !ee_ack) begin
            if (lat_cnt == LAT) begin
               lat_cnt <= 0;
               ee_ack  <= 1'b1;
               req_cnt++;
               if (ee_we) begin
                  eep[ee_addr] <= ee_wdata;
                  wr_cnt++;
               end else begin
                  ee_rdata <= eep[ee_addr];
               end
            end else begin
               lat_cnt <= lat_cnt + 1;
            end
         end
      end
   end

   // Vector table: {is_write, address, data}
   localparam logic [40:0] VEC [NVEC] = '{
      {1'b0, 8'h00, 32'h0},
      {1'b0, 8'h3E, 32'h0},
      {1'b1, 8'h40, 32'hDEAD_BEEF},
      {1'b0, 8'h40, 32'h0},
      {1'b1, 8'h3D, 32'h1122_3344},
      {1'b0, 8'h3C, 32'h0},
      {1'b1, 8'hBC, 32'hCAFE_F00D},
      {1'b1, 8'hBD, 32'h5566_7788},
      {1'b0, 8'hBC, 32'h0},
      {1'b0, 8'hFE, 32'h0}
   };

   function automatic logic [31:0] cmd(input logic f, input logic [7:0] a);
      return {f, 7'b0, a, 16'h0000};
   endfunction

   function automatic bit in_window(input logic [7:0] a);
      for (int k = 0; k < 4; k++) begin
         logic [7:0] b;
         b = a + 8'(k);
         if (b < 8'd64 || b >= 8'd192) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic logic [31:0] ref_word(input logic [7:0] a);
      return {ref_mem[8'(a + 8'd3)], ref_mem[8'(a + 8'd2)], ref_mem[8'(a + 8'd1)], ref_mem[a]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic cfg_wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      pri_sel = sel; pri_wdata = d; pri_wr = 1'b1;
      @(negedge clk);
      pri_wr = 1'b0;
   endtask

   task automatic sec_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      sec_sel = sel; sec_wdata = d; sec_wr = 1'b1;
      @(negedge clk);
      sec_wr = 1'b0;
   endtask

   task automatic cfg_rd(input logic sel, output logic [31:0] d);
      pri_sel = sel;
      #1;
      d = pri_rdata;
   endtask

   task automatic wait_flag(input logic want, output bit ok);
      logic [31:0] v;
      ok = 1'b0;
      for (int n = 0; n < 300; n++) begin
         cfg_rd(1'b0, v);
         if (v[31] == want) begin
            ok = 1'b1;
            break;
         end
         @(negedge clk);
      end
   endtask

   // No request for a number of cycles.
   task automatic quiet(input int cycles, input string tag);
      int seen;
      seen = 0;
      for (int n = 0; n < cycles; n++) begin
         @(negedge clk);
         if (ee_req) seen++;
      end
      chk(tag, 32'(seen), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         eep[i]     = 8'(i * 7 + 3);
         ref_mem[i] = 8'(i * 7 + 3);
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] keep;
      bit ok;
      int w0;

      repeat (3) @(negedge clk);
      // R1 reset values
      cfg_rd(1'b0, v); chk("R1 cap word in reset", v, 32'h0000_0003);
      rst_n = 1'b1;
      @(negedge clk);
      cfg_rd(1'b0, v); chk("R1 cap word", v, 32'h0000_0003);
      cfg_rd(1'b1, v); chk("R1 data word", v, 32'h0);
      chk("R1 ee_req idle", {31'b0, ee_req}, 32'h0);

      // Table walk: R3 reads, R4 writes, R5 protected writes
      for (int i = 0; i < NVEC; i++) begin
         logic       iw;
         logic [7:0] a;
         logic [31:0] d;
         {iw, a, d} = VEC[i];
         if (iw) begin
            w0 = wr_cnt;
            cfg_wr(1'b1, d);
            cfg_wr(1'b0, cmd(1'b1, a));
            wait_flag(1'b0, ok);
            chk("R4 write completes", {31'b0, ok}, 32'd1);
            if (in_window(a)) begin
               chk("R4 four bytes written", 32'(wr_cnt - w0), 32'd4);
               for (int k = 0; k < 4; k++) ref_mem[8'(a + 8'(k))] = d[8*k +: 8];
            end else begin
               chk("R5 no write issued", 32'(wr_cnt - w0), 32'd0);
            end
         end else begin
            cfg_wr(1'b0, cmd(1'b0, a));
            wait_flag(1'b1, ok);
            chk("R3 read completes", {31'b0, ok}, 32'd1);
            cfg_rd(1'b1, v);
            chk("R3 read data", v, ref_word(a));
            cfg_rd(1'b0, v);
            chk("R2 address field", {8'h0, v[23:16], 16'h0}, {8'h0, a, 16'h0});
         end
      end

      // R2 read-only fields and reserved bits
      cfg_wr(1'b0, 32'h7F00_FFFF | cmd(1'b0, 8'h50));
      wait_flag(1'b1, ok);
      cfg_rd(1'b0, v);
      chk("R2 id/next/reserved", v, 32'h8050_0003);

      // R5 flag timing on protected write
      w0 = wr_cnt;
      cfg_wr(1'b0, cmd(1'b1, 8'h10));
      cfg_rd(1'b0, v); chk("R5 flag set for one cycle", {31'b0, v[31]}, 32'd1);
      @(negedge clk);
      cfg_rd(1'b0, v); chk("R5 flag cleared", {31'b0, v[31]}, 32'd0);
      chk("R5 no write at 0x10", 32'(wr_cnt - w0), 32'd0);

      // R8 writes ignored while busy
      w0 = wr_cnt;
      cfg_wr(1'b0, cmd(1'b0, 8'h80));
      cfg_wr(1'b0, cmd(1'b1, 8'h90));
      cfg_wr(1'b1, 32'hFFFF_FFFF);
      wait_flag(1'b1, ok);
      chk("R8 read still completes", {31'b0, ok}, 32'd1);
      cfg_rd(1'b1, v); chk("R8 data not overwritten", v, ref_word(8'h80));
      cfg_rd(1'b0, v); chk("R8 address kept", {24'h0, v[23:16]}, 32'h80);
      chk("R8 no write issued", 32'(wr_cnt - w0), 32'd0);

      // R6 secondary port
      sec_sel = 1'b0; #1; chk("R6 sec cap read", sec_rdata, 32'h0);
      sec_sel = 1'b1; #1; chk("R6 sec data read", sec_rdata, 32'h0);
      cfg_rd(1'b1, keep);
      w0 = req_cnt;
      sec_write(1'b0, cmd(1'b0, 8'h20));
      sec_write(1'b1, 32'h0BAD_0BAD);
      quiet(20, "R6 sec write starts nothing");
      cfg_rd(1'b0, v); chk("R6 cap unchanged", v, 32'h8080_0003);
      cfg_rd(1'b1, v); chk("R6 data unchanged", v, keep);

      // R7 disable
      vpd_enable = 1'b0;
      cfg_rd(1'b0, v); chk("R7 cap reads zero", v, 32'h0);
      cfg_rd(1'b1, v); chk("R7 data reads zero", v, 32'h0);
      cfg_wr(1'b0, cmd(1'b0, 8'h60));
      cfg_wr(1'b1, 32'h1234_5678);
      quiet(20, "R7 disabled write starts nothing");
      vpd_enable = 1'b1;
      cfg_rd(1'b0, v); chk("R7 cap unchanged", v, 32'h8080_0003);
      cfg_rd(1'b1, v); chk("R7 data unchanged", v, keep);

      // R9 each byte costs one acknowledged request
      w0 = req_cnt;
      cfg_wr(1'b0, cmd(1'b0, 8'h44));
      wait_flag(1'b1, ok);
      chk("R9 four requests per read", 32'(req_cnt - w0), 32'd4);

      // R10 reset mid-transfer
      cfg_wr(1'b0, cmd(1'b0, 8'h48));
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R10 ee_req drops", {31'b0, ee_req}, 32'd0);
      cfg_rd(1'b0, v); chk("R10 cap back to reset", v, 32'h0000_0003);
      @(negedge clk);
      rst_n = 1'b1;
      quiet(15, "R10 no request after reset");
      cfg_rd(1'b1, v); chk("R10 data back to reset", v, 32'h0);

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule